// File: doc/BRIEF.md
# Memory Operation Ordering Dispatcher

This block sits at the dispatch stage of an out-of-order core, in front of the load and store queues. Each cycle it can take one memory operation. The operation carries three flags: it reads memory, it writes memory, and it has side effects. The block first checks that the load and store queues have room for the operation. If they do, it places the operation in a dependency group. Operations in the same group never depend on each other. The block then reports the group identifier, plus up to three edges that an external group tracker must add from older groups to this one.

An edge of the "data" kind means the younger group may not start until the older group has fully executed. An edge of the "order" kind only means the younger group must issue after the older group. The block keeps four pointers: the newest load group, the newest load-barrier group, the newest store group and the newest store-barrier group. From these it builds the edges.

A read with side effects becomes a load barrier. A write with side effects becomes a store barrier. An operation that does both is a full barrier. A configuration pin selects whether loads may be assumed not to alias older stores. Queue occupancy drops on load retirement and on store commit. A queue size of zero makes that queue unbounded.

The dispatch input is a valid/ready stream. `disp_ready` is high exactly when the operation currently on the input would be accepted. The producer must hold its operation until a cycle in which valid and ready are both high. The result output has no back-pressure: the tracker must take every result in the cycle it is valid.

Top module: `memord_dispatch`

## Requirements
- R1: `disp_status` is computed without delay from the presented flags and the current occupancy. It is 0 when the operation fits. It is 1 when the operation reads and the load queue is full; this case is checked first. It is 2 when the operation writes, the load case does not apply, and the store queue is full.
- R2: A queue whose size parameter is 0 never reports full, whatever its occupancy.
- R3: Each accepted operation that reads (including a barrier) adds one load-queue entry. Each accepted operation that writes adds one store-queue entry. A pulse on `ld_retire` or `st_commit` frees one entry, and it takes effect from the next cycle. An operation that neither reads nor writes takes no entry.
- R4: `disp_ready` is high exactly when `disp_status` is 0. An operation that is not accepted changes no state and produces no result.
- R5: New groups take identifiers 1, 2, 3, … in order of creation, and after the largest identifier they wrap back to 1. Identifier 0 is never a group: an operation that neither reads nor writes is reported with identifier 0 and no edges.
- R6: Every writing operation opens a new group. Its edges are as follows:
  - Slot 0 points to the newest load group. This edge is of the data kind if that group is also the newest load barrier, and of the order kind otherwise.
  - Slot 1 points to the newest store barrier, as a data edge.
  - Slot 2 points to the newest store group, as an order edge. This slot is used only when that group is not the newest store barrier.
- R7: A plain load joins the newest load group, with no edges, when all of the following hold: that group exists, it is not a load barrier, and no store group has been created since it.
- R8: When a plain load opens a new group and the no-alias pin is low, slot 2 carries a data edge to the newest store group. When the pin is high, the load gets no edge to a store.
- R9: A load barrier opens a new group with a data edge in slot 0 to the newest load group. A plain load that opens a group gets a data edge in slot 0 to the newest load barrier. A full barrier follows the store rules, then becomes the newest load, load-barrier, store and store-barrier group.
- R10: The result (`res_valid`, identifier, edges) appears in the cycle after the accepting clock edge. `res_valid` is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_no_alias | input | 1 | 1: loads may pass older stores |
| disp_valid | input | 1 | Operation present |
| disp_ready | output | 1 | Operation will be accepted this cycle |
| disp_may_load | input | 1 | Operation reads memory |
| disp_may_store | input | 1 | Operation writes memory |
| disp_side_fx | input | 1 | Operation has side effects (barrier) |
| disp_status | output | 2 | 0 fits, 1 load queue full, 2 store queue full |
| ld_retire | input | 1 | One load leaves the load queue |
| st_commit | input | 1 | One store leaves the store queue |
| res_valid | output | 1 | Result valid for one cycle |
| res_gid | output | GID_W | Group identifier, 0 for non-memory |
| res_edge_valid | output | 3 | Edge present per slot (0 load side, 1 store barrier, 2 store) |
| res_edge_data | output | 3 | Per slot: 1 data edge, 0 order edge |
| res_edge_src | output | 3*GID_W | Source group per slot, slot k at bits k*GID_W upward |

## Verification
`disp_status` and `disp_ready` are combinational. The bench drives each operation just after a falling edge and reads status one time unit later, before the next rising edge. The group identifier and edges are registered, so they are read at the falling edge that follows the accepting rising edge. The same falling edge also drives the next operation.

A retire or commit pulse is driven together with an operation. Its effect is therefore visible only in the status of the next operation; the status of the current operation is still computed from the old count. The vector table exploits this by pairing refused operations with retire pulses.

// File: rtl/memord_pkg.sv
package memord_pkg;

  typedef enum logic [1:0] {
    ST_AVAIL   = 2'd0,
    ST_LQ_FULL = 2'd1,
    ST_SQ_FULL = 2'd2
  } memord_status_e;

  localparam int SLOT_LOAD  = 0;
  localparam int SLOT_SBAR  = 1;
  localparam int SLOT_STORE = 2;
  localparam int NUM_SLOTS  = 3;

endpackage

// File: rtl/memord_occupancy.sv
module memord_occupancy #(
  parameter int SIZE = 4,
  parameter int CW   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acq,
  input  logic          rel,
  output logic [CW-1:0] used,
  output logic          full
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used <= '0;
    end else if (acq && !rel) begin
      used <= used + CW'(1);
    end else if (!acq && rel) begin
      used <= used - CW'(1);
    end
  end

  // Acquire without release must advance the count by exactly one.
  assert_count_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acq && !rel) |=> used == $past(used) + CW'(1));

  // A release with nothing acquired needs a non-empty queue.
  assert_release_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rel && !acq) |-> used != '0);

  generate
    if (SIZE == 0) begin : g_unbounded
      assign full = 1'b0;
    end else begin : g_bounded
      assign full = (used == CW'(SIZE));

      assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        used <= CW'(SIZE));
    end
  endgenerate

endmodule

// File: rtl/memord_grouper.sv
module memord_grouper
  import memord_pkg::*;
#(
  parameter int GID_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       accept,
  input  logic                       is_ld,
  input  logic                       is_st,
  input  logic                       side_fx,
  input  logic                       no_alias,
  output logic                       res_valid,
  output logic [GID_W-1:0]           res_gid,
  output logic [NUM_SLOTS-1:0]       res_edge_valid,
  output logic [NUM_SLOTS-1:0]       res_edge_data,
  output logic [NUM_SLOTS*GID_W-1:0] res_edge_src
);

  localparam logic [GID_W-1:0] GID_LAST  = '1;
  localparam logic [GID_W-1:0] GID_FIRST = GID_W'(1);

  logic [GID_W-1:0] cur_ld, cur_ldb, cur_st, cur_stb, nxt_gid;
  logic             st_after_ld;

  logic                 ldbar, stbar, join_grp, new_grp;
  logic [GID_W-1:0]     gid_d;
  logic [NUM_SLOTS-1:0] ev_d, ed_d;
  logic [GID_W-1:0]     src_d [NUM_SLOTS];
  logic [GID_W-1:0]     src_q [NUM_SLOTS];

  always_comb begin
    ldbar    = is_ld & side_fx;
    stbar    = is_st & side_fx;
    join_grp = is_ld & ~is_st & ~ldbar & (cur_ld != '0) &
               (cur_ld != cur_ldb) & ~st_after_ld;
    new_grp  = (is_ld | is_st) & ~join_grp;
    gid_d    = '0;
    ev_d     = '0;
    ed_d     = '0;
    for (int k = 0; k < NUM_SLOTS; k++) src_d[k] = '0;

    if (is_st) begin
      gid_d = nxt_gid;
      if (cur_ld != '0) begin
        ev_d[SLOT_LOAD]  = 1'b1;
        ed_d[SLOT_LOAD]  = (cur_ld == cur_ldb);
        src_d[SLOT_LOAD] = cur_ld;
      end
      if (cur_stb != '0) begin
        ev_d[SLOT_SBAR]  = 1'b1;
        ed_d[SLOT_SBAR]  = 1'b1;
        src_d[SLOT_SBAR] = cur_stb;
      end
      if (cur_st != '0 && cur_st != cur_stb) begin
        ev_d[SLOT_STORE]  = 1'b1;
        src_d[SLOT_STORE] = cur_st;
      end
    end else if (is_ld) begin
      if (join_grp) begin
        gid_d = cur_ld;
      end else begin
        gid_d = nxt_gid;
        if (ldbar && cur_ld != '0) begin
          ev_d[SLOT_LOAD]  = 1'b1;
          ed_d[SLOT_LOAD]  = 1'b1;
          src_d[SLOT_LOAD] = cur_ld;
        end else if (!ldbar && cur_ldb != '0) begin
          ev_d[SLOT_LOAD]  = 1'b1;
          ed_d[SLOT_LOAD]  = 1'b1;
          src_d[SLOT_LOAD] = cur_ldb;
        end
        if (!no_alias && cur_st != '0) begin
          ev_d[SLOT_STORE]  = 1'b1;
          ed_d[SLOT_STORE]  = 1'b1;
          src_d[SLOT_STORE] = cur_st;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_ld         <= '0;
      cur_ldb        <= '0;
      cur_st         <= '0;
      cur_stb        <= '0;
      st_after_ld    <= 1'b0;
      nxt_gid        <= GID_FIRST;
      res_valid      <= 1'b0;
      res_gid        <= '0;
      res_edge_valid <= '0;
      res_edge_data  <= '0;
      for (int k = 0; k < NUM_SLOTS; k++) src_q[k] <= '0;
    end else begin
      res_valid <= accept;
      if (accept) begin
        res_gid        <= gid_d;
        res_edge_valid <= ev_d;
        res_edge_data  <= ed_d;
        for (int k = 0; k < NUM_SLOTS; k++) src_q[k] <= src_d[k];
        if (new_grp) begin
          nxt_gid <= (nxt_gid == GID_LAST) ? GID_FIRST : nxt_gid + GID_W'(1);
          if (is_ld) begin
            cur_ld      <= nxt_gid;
            st_after_ld <= 1'b0;
            if (ldbar) cur_ldb <= nxt_gid;
          end
          if (is_st) begin
            cur_st <= nxt_gid;
            if (stbar) cur_stb <= nxt_gid;
            if (!is_ld) st_after_ld <= 1'b1;
          end
        end
      end
    end
  end

  generate
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_pack
      assign res_edge_src[g*GID_W +: GID_W] = src_q[g];
    end
  endgenerate

  // A writing operation always receives a real group.
  assert_store_gid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_st) |=> (res_gid != '0));

  // A store never passes an older store: some edge must reach the store side.
  assert_store_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_st && cur_st != '0) |=>
      (res_edge_valid[SLOT_SBAR] || res_edge_valid[SLOT_STORE]));

  // Joining loads carry the current load group and no edge.
  assert_join_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && join_grp) |=> (res_edge_valid == '0 && res_gid == $past(cur_ld)));

endmodule

// File: rtl/memord_dispatch.sv
module memord_dispatch
  import memord_pkg::*;
#(
  parameter int LQ_SIZE   = 4,
  parameter int SQ_SIZE   = 4,
  parameter int GID_W     = 8,
  parameter int UNB_CNT_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_no_alias,
  input  logic                       disp_valid,
  output logic                       disp_ready,
  input  logic                       disp_may_load,
  input  logic                       disp_may_store,
  input  logic                       disp_side_fx,
  output logic [1:0]                 disp_status,
  input  logic                       ld_retire,
  input  logic                       st_commit,
  output logic                       res_valid,
  output logic [GID_W-1:0]           res_gid,
  output logic [NUM_SLOTS-1:0]       res_edge_valid,
  output logic [NUM_SLOTS-1:0]       res_edge_data,
  output logic [NUM_SLOTS*GID_W-1:0] res_edge_src
);

  localparam int LQ_CW = (LQ_SIZE == 0) ? UNB_CNT_W : $clog2(LQ_SIZE + 1);
  localparam int SQ_CW = (SQ_SIZE == 0) ? UNB_CNT_W : $clog2(SQ_SIZE + 1);

  logic [LQ_CW-1:0] lq_used;
  logic [SQ_CW-1:0] sq_used;
  logic             lq_full, sq_full, accept;
  memord_status_e   status;

  always_comb begin
    if (disp_may_load && lq_full)       status = ST_LQ_FULL;
    else if (disp_may_store && sq_full) status = ST_SQ_FULL;
    else                                status = ST_AVAIL;
  end

  assign disp_status = status;
  assign disp_ready  = (status == ST_AVAIL);
  assign accept      = disp_valid & disp_ready;

  memord_occupancy #(.SIZE(LQ_SIZE), .CW(LQ_CW)) u_lq (
    .clk  (clk),
    .rst_n(rst_n),
    .acq  (accept & disp_may_load),
    .rel  (ld_retire),
    .used (lq_used),
    .full (lq_full)
  );

  memord_occupancy #(.SIZE(SQ_SIZE), .CW(SQ_CW)) u_sq (
    .clk  (clk),
    .rst_n(rst_n),
    .acq  (accept & disp_may_store),
    .rel  (st_commit),
    .used (sq_used),
    .full (sq_full)
  );

  memord_grouper #(.GID_W(GID_W)) u_grp (
    .clk           (clk),
    .rst_n         (rst_n),
    .accept        (accept),
    .is_ld         (disp_may_load),
    .is_st         (disp_may_store),
    .side_fx       (disp_side_fx),
    .no_alias      (cfg_no_alias),
    .res_valid     (res_valid),
    .res_gid       (res_gid),
    .res_edge_valid(res_edge_valid),
    .res_edge_data (res_edge_data),
    .res_edge_src  (res_edge_src)
  );

  // Result follows acceptance by exactly one cycle.
  assert_result_timing_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ready) |=> res_valid);
  assert_no_spurious_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(disp_valid && disp_ready) |=> !res_valid);

  generate
    if (LQ_SIZE != 0) begin : g_lq_chk
      assert_lq_block_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_may_load && lq_used == LQ_CW'(LQ_SIZE)) |-> disp_status == 2'd1);
    end
    if (SQ_SIZE != 0) begin : g_sq_chk
      assert_sq_block_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_may_store && !disp_may_load && sq_used == SQ_CW'(SQ_SIZE))
          |-> disp_status == 2'd2);
    end
  endgenerate

endmodule

// File: tb/memord_dispatch_tb.sv
module memord_dispatch_tb;

  typedef struct packed {
    logic       ld, st, fx, na, ret, com;
    logic [1:0] est;
    logic [7:0] egid;
    logic [2:0] ev, ed;
    logic [7:0] s2, s1, s0;
  } vec_t;

  localparam int NV = 20;
  // ld st fx na ret com | status gid | edge valid, data (bit2=store slot) | src2 src1 src0
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0, 8'd1,  3'b000,3'b000, 8'd0,8'd0,8'd0},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0, 8'd1,  3'b000,3'b000, 8'd0,8'd0,8'd0},
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 2'd0, 8'd2,  3'b001,3'b000, 8'd0,8'd0,8'd1},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0, 8'd3,  3'b100,3'b100, 8'd2,8'd0,8'd0},
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 2'd0, 8'd4,  3'b101,3'b000, 8'd2,8'd0,8'd3},
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 2'd0, 8'd5,  3'b000,3'b000, 8'd0,8'd0,8'd0},
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0, 2'd1, 8'd0,  3'b000,3'b000, 8'd0,8'd0,8'd0},
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 2'd0, 8'd5,  3'b000,3'b000, 8'd0,8'd0,8'd0},
    '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0, 2'd1, 8'd0,  3'b000,3'b000, 8'd0,8'd0,8'd0},
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 2'd0, 8'd6,  3'b101,3'b101, 8'd4,8'd0,8'd5},
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 2'd0, 8'd7,  3'b101,3'b001, 8'd4,8'd0,8'd6},
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 2'd0, 8'd8,  3'b011,3'b011, 8'd0,8'd7,8'd6},
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b1, 2'd2, 8'd0,  3'b000,3'b000, 8'd0,8'd0,8'd0},
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 2'd0, 8'd0,  3'b000,3'b000, 8'd0,8'd0,8'd0},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0, 8'd9,  3'b101,3'b101, 8'd8,8'd0,8'd6},
    '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b0, 2'd1, 8'd0,  3'b000,3'b000, 8'd0,8'd0,8'd0},
    '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 2'd0, 8'd10, 3'b111,3'b010, 8'd8,8'd7,8'd9},
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1, 2'd1, 8'd0,  3'b000,3'b000, 8'd0,8'd0,8'd0},
    '{0'b0+1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 2'd0, 8'd11, 3'b011,3'b011, 8'd0,8'd10,8'd10},
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 2'd2, 8'd0,  3'b000,3'b000, 8'd0,8'd0,8'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic na = 1'b0, dv = 1'b0, ml = 1'b0, ms = 1'b0, fx = 1'b0, ret = 1'b0, com = 1'b0;
  logic        rdy, rv;
  logic [1:0]  sts;
  logic [7:0]  gid;
  logic [2:0]  ev, ed;
  logic [23:0] src;

  logic        u_dv = 1'b0;
  logic        u_rdy, u_rv;
  logic [1:0]  u_sts;
  logic [7:0]  u_gid;
  logic [2:0]  u_ev, u_ed;
  logic [23:0] u_src;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  memord_dispatch u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_no_alias(na), .disp_valid(dv), .disp_ready(rdy),
    .disp_may_load(ml), .disp_may_store(ms), .disp_side_fx(fx), .disp_status(sts),
    .ld_retire(ret), .st_commit(com), .res_valid(rv), .res_gid(gid),
    .res_edge_valid(ev), .res_edge_data(ed), .res_edge_src(src)
  );

  memord_dispatch #(.LQ_SIZE(0), .SQ_SIZE(0)) u_unb (
    .clk(clk), .rst_n(rst_n), .cfg_no_alias(1'b0), .disp_valid(u_dv), .disp_ready(u_rdy),
    .disp_may_load(1'b0), .disp_may_store(1'b1), .disp_side_fx(1'b0), .disp_status(u_sts),
    .ld_retire(1'b0), .st_commit(1'b0), .res_valid(u_rv), .res_gid(u_gid),
    .res_edge_valid(u_ev), .res_edge_data(u_ed), .res_edge_src(u_src)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_res(input vec_t v, input int idx);
    if (v.est == 2'd0) begin
      chk("R10", $sformatf("v%0d res_valid", idx), 32'(rv), 32'd1);
      chk("R5", $sformatf("v%0d gid", idx), 32'(gid), 32'(v.egid));
      chk("R6", $sformatf("v%0d edge_valid", idx), 32'(ev), 32'(v.ev));
      chk("R9", $sformatf("v%0d edge_data", idx), 32'(ed & v.ev), 32'(v.ed));
      for (int k = 0; k < 3; k++) begin
        if (v.ev[k]) begin
          chk("R8", $sformatf("v%0d src slot %0d", idx, k), 32'(src[k*8 +: 8]),
              32'({v.s2, v.s1, v.s0} >> (k*8)) & 32'hFF);
        end
      end
    end else begin
      chk("R4", $sformatf("v%0d refused res_valid", idx), 32'(rv), 32'd0);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // Reset state
    repeat (3) @(negedge clk);
    ml = 1'b1;
    #1;
    chk("R10", "reset res_valid", 32'(rv), 32'd0);
    chk("R1", "reset status", 32'(sts), 32'd0);
    chk("R4", "reset ready", 32'(rdy), 32'd1);
    rst_n = 1'b1;
    // Operation presented without valid: ignored (R4)
    @(negedge clk);
    chk("R4", "no-valid res_valid", 32'(rv), 32'd0);

    // Vector table, R1 R2 R3 R5 R6 R7 R8 R9 exercised through the sequence
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      if (i > 0) check_res(VECS[i-1], i-1);
      dv = 1'b1;
      ml = VECS[i].ld; ms = VECS[i].st; fx = VECS[i].fx;
      na = VECS[i].na; ret = VECS[i].ret; com = VECS[i].com;
      #1;
      chk("R1", $sformatf("v%0d status", i), 32'(sts), 32'(VECS[i].est));
      chk("R4", $sformatf("v%0d ready", i), 32'(rdy), 32'(VECS[i].est == 2'd0));
    end
    @(negedge clk);
    check_res(VECS[NV-1], NV-1);
    dv = 1'b0; ret = 1'b0; com = 1'b0; ml = 1'b0; ms = 1'b0; fx = 1'b0;

    // R3: both queues still full after v20 refused (lu=3, su=4): a store is refused
    ms = 1'b1;
    #1;
    chk("R3", "store queue still full", 32'(sts), 32'd2);
    ms = 1'b0;

    // Reset clears grouping state: next store is group 1 with no edges (R5)
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10", "mid reset res_valid", 32'(rv), 32'd0);
    rst_n = 1'b1;
    dv = 1'b1; ms = 1'b1;
    @(negedge clk);
    dv = 1'b0; ms = 1'b0;
    chk("R5", "post reset gid", 32'(gid), 32'd1);
    chk("R6", "post reset edges", 32'(ev), 32'd0);

    // R2: unbounded queues accept many stores
    for (int i = 0; i < 20; i++) begin
      u_dv = 1'b1;
      #1;
      chk("R2", $sformatf("unbounded ready %0d", i), 32'(u_rdy), 32'd1);
      @(negedge clk);
      chk("R5", $sformatf("unbounded gid %0d", i), 32'(u_gid), 32'(i + 1));
    end
    u_dv = 1'b0;
    @(negedge clk);
    chk("R10", "unbounded idle", 32'(u_rv), 32'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule